// File: doc/BRIEF.md
# Processor Control Pin Conditioner

This block sits between a handful of asynchronous processor control pins and the core. Each pin is brought into the core clock domain by a two-stage synchroniser. A per-pin register then holds the last level the block acted on. Work is done only when the synchronised level differs from that stored level, so a level that repeats is treated as spurious and dropped.

On a genuine change, the pin's role decides what happens:
- the external-interrupt, thermal-interrupt and soft-reset pins each drive a pending bit that tracks the pin;
- the machine-check pin latches its pending bit on a falling edge, and the bit stays set until acknowledged;
- the checkstop pin halts the core until the block is reset;
- the time-base pin starts and freezes a run output for the time base.

Pins above the defined roles are spare and are ignored. Priority, vectoring and core reset sequencing are left to other blocks.

Top module: `pin_cond`

## Requirements
- R1: A pin change is synchronised by two flops and then registered once. The reacting output updates on the third rising clock edge that samples the new pin level, counting the first such edge. It is unchanged after the second edge.
- R2: The block acts only when a synchronised pin level differs from the stored level for that pin. A level that stays the same causes no action. For example, a machine-check bit that has been acknowledged is not set again while the pin stays low.
- R3: Pending bit 0 follows pin 0 (external interrupt, active high). Pending bit 1 follows pin 1 (thermal interrupt, active high).
- R4: A 1-to-0 change on pin 2 (machine check) sets pending bit 2. A 0-to-1 change on that pin leaves the bit unchanged. Once set, the bit holds until `ack_mc_i` is high at a clock edge, which clears it. A falling edge in the same cycle as the acknowledge keeps the bit set.
- R5: A change of pin 3 (checkstop) to high sets `halted_o`. The flag stays set whatever the pin does afterwards. Only `rst_n` clears it.
- R6: `tb_run_o` follows pin 4 (time-base enable, active high). A high level starts the time base and a low level freezes it.
- R7: Pending bit 3 (reset interrupt) follows pin 5 (soft reset).
- R8: Pins 6 and above have no role. Toggling them changes no output.
- R9: While `rst_n` is low at a clock edge, all stored levels, pending bits, `halted_o` and `tb_run_o` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_PINS (8) | Raw asynchronous control pins, roles by index as in R3 to R8 |
| ack_mc_i | input | 1 | Clears the latched machine-check pending bit |
| pend_o | output | 4 | Pending bits: 0 external, 1 thermal, 2 machine check, 3 reset interrupt |
| halted_o | output | 1 | Core halted by checkstop |
| tb_run_o | output | 1 | Time base running |

## Verification
The hardest situation to reach from the ports is a machine-check edge judged against a stored level that is not the reset value. The bit must be acknowledged while the pin stays low, and the same level must then be presented again to show it is filtered out. A second case is walking the checkstop pin through every pattern without the halt hiding the other pins.

The stimulus covers this with two sweeps over all 256 pin patterns. An ascending sweep keeps checkstop low and produces a machine-check fall every eighth step. A descending sweep includes checkstop. Between the two sweeps comes an acknowledge with the pin pattern held. The bench predicts every output from the previously applied pattern.

// File: rtl/pinc_pkg.sv
// Shared role map for the control pin conditioner.
// Assumes pin indices 0..5 carry roles and any higher index is spare.
package pinc_pkg;
    localparam int PIN_EXT    = 0;
    localparam int PIN_THERM  = 1;
    localparam int PIN_MCHK   = 2;
    localparam int PIN_CKSTOP = 3;
    localparam int PIN_TBEN   = 4;
    localparam int PIN_SRST   = 5;
    localparam int NUM_ROLES  = 6;

    localparam int PEND_EXT   = 0;
    localparam int PEND_THERM = 1;
    localparam int PEND_MCHK  = 2;
    localparam int PEND_SRST  = 3;
    localparam int NUM_PEND   = 4;
endpackage

// File: rtl/pinc_sync.sv
// Multi-stage synchroniser, one chain per pin.
// Assumes pins are quasi-static relative to clk; no glitch filtering.
module pinc_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-samples the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pinc_change_det.sv
// Keeps the last acted-on level per role pin and flags real changes.
// Assumes bits at or above KNOWN are spare: their stored level is never updated.
module pinc_change_det #(
    parameter int WIDTH = 8,
    parameter int KNOWN = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] evt_o
);
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        if (gi < KNOWN) begin : g_role
            logic held_q;
            // Record the level each time a change is processed.
            always_ff @(posedge clk) begin
                if (!rst_n)          held_q <= 1'b0;
                else if (evt_o[gi])  held_q <= lvl_i[gi];
            end
            assign evt_o[gi] = lvl_i[gi] ^ held_q;
        end else begin : g_spare
            // Spare pins pass a raw indication; the decoder drops it.
            assign evt_o[gi] = lvl_i[gi];
        end
    end
endmodule

// File: rtl/pinc_decode.sv
// Turns per-pin change events into pending bits, halt and time-base run.
// Assumes evt_i is high only in the cycle a pin's level changed.
module pinc_decode
    import pinc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WIDTH-1:0]    lvl_i,
    input  logic [WIDTH-1:0]    evt_i,
    input  logic                ack_mc_i,
    output logic [NUM_PEND-1:0] pend_o,
    output logic                halted_o,
    output logic                tb_run_o
);
    logic [NUM_PEND-1:0] pend_q;
    logic                halt_q;
    logic                tb_q;

    // Apply each pin's role on its change event; acknowledge loses to a new edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            halt_q <= 1'b0;
            tb_q   <= 1'b0;
        end else begin
            if (ack_mc_i) pend_q[PEND_MCHK] <= 1'b0;
            for (int i = 0; i < WIDTH; i++) begin
                if (evt_i[i]) begin
                    case (i)
                        PIN_EXT:    pend_q[PEND_EXT]   <= lvl_i[i];
                        PIN_THERM:  pend_q[PEND_THERM] <= lvl_i[i];
                        PIN_MCHK:   if (!lvl_i[i]) pend_q[PEND_MCHK] <= 1'b1;
                        PIN_CKSTOP: if (lvl_i[i])  halt_q <= 1'b1;
                        PIN_TBEN:   tb_q <= lvl_i[i];
                        PIN_SRST:   pend_q[PEND_SRST]  <= lvl_i[i];
                        default:    ;
                    endcase
                end
            end
        end
    end

    assign pend_o   = pend_q;
    assign halted_o = halt_q;
    assign tb_run_o = tb_q;
endmodule

// File: rtl/pin_cond.sv
// Top of the control pin conditioner: synchroniser, change detector, decoder.
// Assumes NUM_PINS >= the number of role pins in pinc_pkg.
module pin_cond
    import pinc_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                ack_mc_i,
    output logic [NUM_PEND-1:0] pend_o,
    output logic                halted_o,
    output logic                tb_run_o
);
    logic [NUM_PINS-1:0] sync_w;
    logic [NUM_PINS-1:0] evt_w;

    pinc_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(sync_w)
    );

    pinc_change_det #(.WIDTH(NUM_PINS), .KNOWN(NUM_ROLES)) u_det (
        .clk(clk), .rst_n(rst_n), .lvl_i(sync_w), .evt_o(evt_w)
    );

    pinc_decode #(.WIDTH(NUM_PINS)) u_dec (
        .clk(clk), .rst_n(rst_n), .lvl_i(sync_w), .evt_i(evt_w),
        .ack_mc_i(ack_mc_i), .pend_o(pend_o), .halted_o(halted_o),
        .tb_run_o(tb_run_o)
    );
endmodule

// File: rtl/pinc_checker.sv
// Property checker for pin_cond, attached by bind to the top.
// Assumes it sees the synchronised levels and change events of the top.
module pinc_checker
    import pinc_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] sync_lvl,
    input logic [NUM_PINS-1:0] pin_evt,
    input logic                ack_mc_i,
    input logic [NUM_PEND-1:0] pend_o,
    input logic                halted_o,
    input logic                tb_run_o
);
    p_ext_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_evt[PIN_EXT] |=> pend_o[PEND_EXT] == $past(sync_lvl[PIN_EXT]));
    p_therm_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_evt[PIN_THERM] |=> pend_o[PEND_THERM] == $past(sync_lvl[PIN_THERM]));
    p_mc_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_evt[PIN_MCHK] && !sync_lvl[PIN_MCHK]) |=> pend_o[PEND_MCHK]);
    p_mc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o[PEND_MCHK] && !ack_mc_i) |=> pend_o[PEND_MCHK]);
    p_mc_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_mc_i && !(pin_evt[PIN_MCHK] && !sync_lvl[PIN_MCHK])) |=> !pend_o[PEND_MCHK]);
    p_halt_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_evt[PIN_CKSTOP] && sync_lvl[PIN_CKSTOP]) |=> halted_o);
    p_halt_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> halted_o);
    p_tb_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_evt[PIN_TBEN] |=> tb_run_o == $past(sync_lvl[PIN_TBEN]));
    p_srst_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_evt[PIN_SRST] |=> pend_o[PEND_SRST] == $past(sync_lvl[PIN_SRST]));
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_evt[NUM_ROLES-1:0] == '0) |=> ($stable(tb_run_o) && $stable(halted_o)
            && $stable(pend_o[PEND_THERM:PEND_EXT]) && $stable(pend_o[PEND_SRST])));
endmodule

bind pin_cond pinc_checker #(.NUM_PINS(NUM_PINS)) u_pinc_chk (
    .clk(clk), .rst_n(rst_n), .sync_lvl(sync_w), .pin_evt(evt_w),
    .ack_mc_i(ack_mc_i), .pend_o(pend_o), .halted_o(halted_o), .tb_run_o(tb_run_o)
);

// File: tb/pin_cond_bench.sv
module pin_cond_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = '0;
    logic       ack_mc = 1'b0;
    logic [3:0] pend;
    logic       halted;
    logic       tb_run;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Model state, derived from the requirements only.
    logic [7:0] prev;
    logic e_ext, e_therm, e_mc, e_halt, e_tb, e_srst;

    always #4 clk = ~clk;

    pin_cond u_pin_cond (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .ack_mc_i(ack_mc),
        .pend_o(pend), .halted_o(halted), .tb_run_o(tb_run)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h pins=%h", tag, act, exp, pins);
        end
    endtask

    task automatic check_all(input string extra);
        chk({"R3 ", extra}, {6'd0, pend[1:0]}, {6'd0, e_therm, e_ext});
        chk({"R4 ", extra}, {7'd0, pend[2]}, {7'd0, e_mc});
        chk({"R7 ", extra}, {7'd0, pend[3]}, {7'd0, e_srst});
        chk({"R5 ", extra}, {7'd0, halted}, {7'd0, e_halt});
        chk({"R6 ", extra}, {7'd0, tb_run}, {7'd0, e_tb});
    endtask

    task automatic model_reset();
        prev = '0;
        {e_ext, e_therm, e_mc, e_halt, e_tb, e_srst} = '0;
    endtask

    task automatic model_step(input logic [7:0] v);
        e_ext   = v[0];
        e_therm = v[1];
        if (prev[2] && !v[2]) e_mc = 1'b1;
        if (v[3]) e_halt = 1'b1;
        e_tb    = v[4];
        e_srst  = v[5];
        prev    = v;
    endtask

    task automatic apply(input logic [7:0] v, input string extra);
        @(negedge clk);
        pins = v;
        model_step(v);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all(extra);
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        ack_mc = 1'b1;
        @(negedge clk);
        ack_mc = 1'b0;
        e_mc = 1'b0;
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R9 reset");
        rst_n = 1'b1;

        // R1: latency of exactly three sampling edges.
        @(negedge clk);
        pins = 8'h01;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 not yet", {7'd0, pend[0]}, 8'h00);
        @(posedge clk);
        @(negedge clk);
        chk("R1 third edge", {7'd0, pend[0]}, 8'h01);
        model_step(8'h01);

        // Ascending sweep without checkstop.
        for (int i = 0; i < 256; i++) apply(8'(i) & 8'hF7, "sweep up");

        // R2/R4: hold machine-check low, acknowledge, re-present same level.
        apply(8'h00, "mc low");
        apply(8'h04, "mc rise");
        chk("R4 rise no set", {7'd0, pend[2]}, {7'd0, e_mc});
        apply(8'h00, "mc fall");
        chk("R4 fall sets", {7'd0, pend[2]}, 8'h01);
        ack_pulse();
        @(negedge clk);
        chk("R4 ack clears", {7'd0, pend[2]}, 8'h00);
        apply(8'h00, "R2 repeat level");
        repeat (4) @(negedge clk);
        chk("R2 no re-set", {7'd0, pend[2]}, 8'h00);

        // R8: spare pins only.
        for (int k = 0; k < 4; k++) apply({2'(k), 6'b0}, "R8 spare");
        for (int k = 0; k < 4; k++) apply({2'(k), 6'b010011}, "R8 spare held");

        // Descending sweep including checkstop.
        for (int i = 255; i >= 0; i--) apply(8'(i), "sweep down");
        apply(8'h00, "R5 pin low");
        chk("R5 still halted", {7'd0, halted}, 8'h01);

        // R9/R5: reset clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_all("R9 R5 after reset");
        rst_n = 1'b1;
        apply(8'h30, "after reset");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule